// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Counter

This block raises a CPU interrupt after a programmed number of video scanlines, even though it only sees the CPU clock. A dot prescaler gains three for every enabled CPU cycle. When it reaches one line's worth of dots (341), it subtracts that amount and steps an 8-bit up-counter. When the counter wraps past 0xFF, it reloads from a software-written latch and sets a sticky, active-high interrupt request.

Software controls the block through four write-only registers in the top 4 KiB of the CPU address space. One register holds the low nibble of the reload value. One holds the high nibble. A control register starts a count period. An acknowledge register clears the request and can switch counting on or off, using a saved enable bit. The block needs only a CPU-cycle enable, a write strobe, the address and the data.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the interrupt request is 0, and the enable field, reload latch, counter and prescaler are all 0.
- R2: A write whose decoded register index is 0 loads data bits 3:0 into latch bits 3:0. A write with index 2 or 8 loads data bits 3:0 into latch bits 7:4. Each of these writes clears the interrupt request.
- R3: A write with index 1 or 4 sets the two-bit enable field to data bits 1:0, copies the latch into the counter, zeroes the prescaler and clears the interrupt request.
- R4: A write with index 3 or 12 sets both enable bits equal to the current enable bit 0 and clears the interrupt request. It leaves the counter and prescaler unchanged.
- R5: The prescaler and counter advance only on cycles where cpu_ce is 1 and enable bit 1 is set. Each such cycle adds 3 to the prescaler. If the sum is 341 or more, 341 is subtracted and the counter steps by one.
- R6: A counter step from 0xFF reloads the counter from the latch and sets the interrupt request. With latch L loaded by a control write, the request rises on enabled cycle ceil(341*(256-L)/3). The following request rises on cycle ceil(341*2*(256-L)/3), counted from the same write.
- R7: Once set, the interrupt request stays 1 until one of the writes in R2, R3 or R4 clears it.
- R8: Only address bits 15:12 (which must be 0xF) and bits 3:0 (the register index) are decoded, so bits 11:4 are don't-care. Any write with another top nibble, or with an index outside {0,1,2,3,4,8,12}, has no effect.
- R9: A control write (R3) that arrives on a cpu_ce cycle overrides that cycle's count step. Counting restarts from the freshly loaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | One-cycle pulse per CPU cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Sticky active-high interrupt request |

## Verification
Every register write takes effect at the clock edge that samples it, so a write's clearing of irq is visible one cycle after the strobe. A request set by counting becomes visible after the exact enabled CPU cycle that wraps the counter, because irq is itself a register. The bench computes that cycle as ceil(341*T/3), where T is the number of counter steps. It drives inputs on the falling edge and samples irq one falling edge after each enabled pulse. It checks irq low after cycle N-1 and high after cycle N. This places each expected rise on its exact cycle across a sweep of latch values and gapped enables.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    // Register operation selected by one bus write.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LAT_LO = 3'd1,
        OP_LAT_HI = 3'd2,
        OP_CTRL   = 3'd3,
        OP_ACK    = 3'd4
    } reg_op_e;

    // Dots gained per CPU cycle and dots per scanline.
    localparam int unsigned DOT_STEP  = 3;
    localparam int unsigned LINE_DOTS = 341;

endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode
    import scanirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output reg_op_e           op
);
    localparam int unsigned TOP_W = 4;
    localparam int unsigned IDX_W = 4;

    logic [TOP_W-1:0] region;
    logic [IDX_W-1:0] index;

    assign region = wr_addr[ADDR_W-1 -: TOP_W];
    assign index  = wr_addr[IDX_W-1:0];

    always_comb begin
        op = OP_NONE;
        if (wr_en && (region == {TOP_W{1'b1}})) begin
            case (index)
                4'h0:        op = OP_LAT_LO;
                4'h2, 4'h8:  op = OP_LAT_HI;
                4'h1, 4'h4:  op = OP_CTRL;
                4'h3, 4'hC:  op = OP_ACK;
                default:     op = OP_NONE;
            endcase
        end
    end

    // Middle address bits are mirrors.
    logic unused_mid;
    assign unused_mid = ^wr_addr[ADDR_W-TOP_W-1:IDX_W];

endmodule

// File: rtl/scanirq_prescale.sv
module scanirq_prescale #(
    parameter int unsigned STEP   = 3,
    parameter int unsigned PERIOD = 341,
    localparam int unsigned PRE_W = $clog2(PERIOD + STEP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [PRE_W-1:0] pre_q,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.pre} + (PRE_W+1)'(STEP);
        tick = advance && (sum >= (PRE_W+1)'(PERIOD));
        if (clear) begin
            st_d.pre = '0;
        end else if (advance) begin
            if (tick) begin
                st_d.pre = PRE_W'(sum - (PRE_W+1)'(PERIOD));
            end else begin
                st_d.pre = PRE_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_q = st_q.pre;

endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
    import scanirq_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned EN_W  = 2,
    localparam int unsigned NIB_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_op_e          op,
    input  logic [NIB_W-1:0] data,
    input  logic             tick,
    output logic [EN_W-1:0]  en_q,
    output logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q
);
    typedef struct packed {
        logic [EN_W-1:0]  en;
        logic [CNT_W-1:0] latch;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Register writes first; all of them drop the request.
        case (op)
            OP_LAT_LO: begin
                st_d.latch[NIB_W-1:0] = data;
                st_d.irq = 1'b0;
            end
            OP_LAT_HI: begin
                st_d.latch[CNT_W-1:NIB_W] = data;
                st_d.irq = 1'b0;
            end
            OP_CTRL: begin
                st_d.en  = data[EN_W-1:0];
                st_d.cnt = st_q.latch;
                st_d.irq = 1'b0;
            end
            OP_ACK: begin
                st_d.en  = {EN_W{st_q.en[0]}};
                st_d.irq = 1'b0;
            end
            default: ;
        endcase
        // A line step wins over a same-cycle clear.
        if (tick) begin
            if (st_q.cnt == {CNT_W{1'b1}}) begin
                st_d.cnt = st_q.latch;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q    = st_q.en;
    assign latch_q = st_q.latch;
    assign cnt_q   = st_q.cnt;
    assign irq_q   = st_q.irq;

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
    import scanirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned NIB_W = CNT_W / 2,
    localparam int unsigned PRE_W = $clog2(LINE_DOTS + DOT_STEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    reg_op_e          op;
    logic [1:0]       en_q;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic             advance;
    logic             restart;

    scanirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    assign restart = (op == OP_CTRL);
    assign advance = cpu_ce && en_q[1] && !restart;

    scanirq_prescale #(.STEP(DOT_STEP), .PERIOD(LINE_DOTS)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .advance (advance),
        .pre_q   (pre_q),
        .tick    (tick)
    );

    scanirq_core #(.CNT_W(CNT_W), .EN_W(2)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .data    (wr_data[NIB_W-1:0]),
        .tick    (tick),
        .en_q    (en_q),
        .latch_q (latch_q),
        .cnt_q   (cnt_q),
        .irq_q   (irq)
    );

    logic unused_data;
    assign unused_data = ^wr_data[DATA_W-1:NIB_W];

endmodule

// File: rtl/scanirq_checks.sv
module scanirq_checks #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRE_W  = 9,
    parameter int unsigned PERIOD = 341
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ce,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input logic [1:0]        en_q,
    input logic [CNT_W-1:0]  latch_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [PRE_W-1:0]  pre_q
);
    logic in_region, is_ctrl, is_ack;
    assign in_region = wr_en && (wr_addr[ADDR_W-1 -: 4] == 4'hF);
    assign is_ctrl   = in_region && (wr_addr[3:0] == 4'h1 || wr_addr[3:0] == 4'h4);
    assign is_ack    = in_region && (wr_addr[3:0] == 4'h3 || wr_addr[3:0] == 4'hC);

    p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pre_q) < PERIOD);

    p_rise_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(en_q[1]) && $past(cpu_ce));

    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl |=> (cnt_q == $past(latch_q)) && (pre_q == '0) && !irq);

    p_ack_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> (en_q[1] == en_q[0]) && (en_q[0] == $past(en_q[0])));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ce && !wr_en) |=> $stable(cnt_q) && $stable(pre_q) && $stable(irq));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);

endmodule

bind scanline_irq_timer scanirq_checks #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .PERIOD(scanirq_pkg::LINE_DOTS)
) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_ce  (cpu_ce),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq     (irq),
    .en_q    (en_q),
    .latch_q (latch_q),
    .cnt_q   (cnt_q),
    .pre_q   (pre_q)
);

// File: tb/scanline_irq_timer_bench.sv
module scanline_irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scanline_irq_timer u_scanline_irq_timer (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int due(input int steps);
        return (341 * steps + 2) / 3;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit ce);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cpu_ce = ce;
        @(negedge clk);
        wr_en = 1'b0; cpu_ce = 1'b0;
    endtask

    task automatic run(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cpu_ce = 1'b1;
            if (gap) begin
                @(negedge clk) cpu_ce = 1'b0;
            end
        end
        @(negedge clk) cpu_ce = 1'b0;
    endtask

    task automatic expect_rise(input int n, input bit gap, input string tag);
        run(n - 1, gap);
        chk({tag, " low before due"}, int'(irq), 0);
        run(1, gap);
        chk({tag, " high at due"}, int'(irq), 1);
    endtask

    task automatic set_latch(input logic [7:0] v, input bit alt);
        wr(16'hF000, {4'hA, v[3:0]}, 1'b0);
        wr(alt ? 16'hF008 : 16'hF002, {4'h5, v[7:4]}, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq idle", int'(irq), 0);

        // R1: latch is zero out of reset, so a full 256-line period
        wr(16'hF001, 8'h02, 1'b0);
        expect_rise(due(256), 1'b0, "R1 R6 reset latch 0");

        // R2 R6: sweep of latch values, alternating high-nibble alias
        for (int l = 'hF0; l <= 'hFF; l++) begin
            set_latch(8'(l), l[0]);
            if (l == 'hF0) chk("R2 latch write clears irq", int'(irq), 0);
            wr(16'hF004, 8'h06, 1'b0);
            expect_rise(due(256 - l), 1'b0, "R2 R6 sweep");
        end

        // R7 sticky, R4 ack clear, R6 reload period
        set_latch(8'hFF, 1'b0);
        wr(16'hF001, 8'h03, 1'b0);
        expect_rise(due(1), 1'b0, "R6 latch FF");
        run(30, 1'b0);
        chk("R7 irq held", int'(irq), 1);
        wr(16'hF003, 8'h00, 1'b0);
        chk("R4 ack clears", int'(irq), 0);
        expect_rise(due(2) - due(1) - 30, 1'b0, "R6 reload second period");
        wr(16'hF00C, 8'h00, 1'b0);
        chk("R4 ack alias clears", int'(irq), 0);

        // R5 R4: bit 1 clear stops counting; ack copies bit 0 up
        wr(16'hF001, 8'h01, 1'b0);
        run(400, 1'b0);
        chk("R5 no count with enable bit1 clear", int'(irq), 0);
        wr(16'hF003, 8'h00, 1'b0);
        expect_rise(due(1), 1'b0, "R4 ack enables from held state");
        wr(16'hF001, 8'h02, 1'b0);
        run(50, 1'b0);
        wr(16'hF00C, 8'h00, 1'b0);
        run(400, 1'b0);
        chk("R4 ack with bit0 clear stops", int'(irq), 0);

        // R5: gapped cpu_ce counts enabled cycles only
        wr(16'hF004, 8'h02, 1'b0);
        expect_rise(due(1), 1'b1, "R5 gapped enable");

        // R9: control write on a cpu_ce cycle restarts cleanly
        wr(16'hF001, 8'h02, 1'b0);
        run(100, 1'b0);
        wr(16'hF001, 8'h02, 1'b1);
        chk("R9 restart clears irq", int'(irq), 0);
        expect_rise(due(1), 1'b0, "R9 restart timing");

        // R8: foreign and unlisted writes ignored, mirrors decoded
        wr(16'hE000, 8'h00, 1'b0);
        wr(16'hF006, 8'h00, 1'b0);
        wr(16'h7002, 8'h00, 1'b0);
        chk("R8 ignored writes keep irq", int'(irq), 1);
        wr(16'hF5A4, 8'h02, 1'b0);
        chk("R8 mirror control clears irq", int'(irq), 0);
        expect_rise(due(1), 1'b0, "R8 latch untouched by ignored writes");
        wr(16'hF7F0, 8'h0E, 1'b0);
        wr(16'hF001, 8'h02, 1'b0);
        expect_rise(due(2), 1'b0, "R8 mirror low nibble");

        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule